// File: doc/BRIEF.md
# Single-Cycle RV32 Load/Store Datapath

This block executes one 32-bit instruction per clock from a small integer subset: register-register ALU operations, ALU operations with a 12-bit immediate, word loads and word stores. An internal decoder turns the instruction word into control for the datapath. The datapath has four parts: a 32-entry register file with two operand read ports, a shared ALU, a word-organised data memory, and the multiplexers that pick the second operand and the writeback value. Memory addresses come from the same ALU add that `addi` uses. The value written back to the register file is the memory read data for a load and the ALU result for everything else.

Instructions arrive on a valid/ready stream. A beat is taken on every rising edge where `instr_valid` and `instr_ready` are both high. `instr_ready` is low while reset is asserted and high at all other times, so the block never applies back-pressure once it is out of reset. While `instr_valid` is low, `instr` is a don't-care. Register and memory contents can be read at any time through two combinational inspection ports. Fetch, program counter handling, branches, sub-word and misaligned accesses are handled elsewhere.

Top module: `rvdp_core`

## Requirements
- R1: While `rst_n` is low, `instr_ready` is 0. After reset, every register and every memory word reads 0 on the inspection ports.
- R2: Register x0 always reads 0, and any instruction that writes to x0 leaves it at 0.
- R3: Opcode 0x33 writes rd with the result of an operation on rs1 and rs2, selected by funct3 (bits 14:12):
  - 000 is add, or sub when bit 30 is set;
  - 001 is shift left;
  - 010 is signed less-than and 011 is unsigned less-than, each giving 0 or 1;
  - 100 is xor;
  - 101 is logical right shift, or arithmetic right shift when bit 30 is set;
  - 110 is or and 111 is and.
  
  Shift amounts use only the low 5 bits of rs2. Bit 30 has no effect for any other funct3.
- R4: Opcode 0x13 applies the same funct3 operations as R3 to rs1 and the sign-extended immediate in bits 31:20. There is no subtract. Bit 30 selects an arithmetic right shift only when funct3 is 101.
- R5: Opcode 0x03 with funct3 010 writes rd with the whole memory word at word address (rs1 + sign-extended bits 31:20) bits [ADDR_W+1:2], where ADDR_W = log2(MEM_WORDS).
- R6: Opcode 0x23 with funct3 010 writes rs2 into the memory word at (rs1 + sign-extended {bits 31:25, bits 11:7}) bits [ADDR_W+1:2]. It writes no register, even though bits 11:7 name one.
- R7: The state change of an accepted instruction is visible on the inspection ports right after the rising edge that accepts it. The next instruction, accepted back-to-back, already reads the new value.
- R8: A cycle with `instr_valid` low changes no register and no memory word.
- R9: Any other opcode, and a load or store whose funct3 is not 010, changes no register and no memory word.
- R10: Memory word addresses wrap modulo MEM_WORDS. Byte address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction beat is present |
| instr_ready | output | 1 | Block accepts a beat (low only in reset) |
| instr | input | 32 | Instruction word |
| dbg_reg_addr | input | 5 | Register index to inspect |
| dbg_reg_data | output | 32 | Combinational read of the inspected register |
| dbg_mem_addr | input | log2(MEM_WORDS) | Memory word index to inspect |
| dbg_mem_data | output | 32 | Combinational read of the inspected memory word |

## Verification
Every result is due exactly one rising edge after the beat is accepted. No register sits between decode, ALU, memory read and writeback, and the inspection reads are combinational.

The bench drives each beat just after a falling edge and drops `instr_valid` at the next falling edge. It then sets the inspection address and samples a short time later, still in the low half of the clock. This places every check after the committing edge and before the next one.

Back-to-back beats confirm that a following instruction sees the value committed on the previous edge. Idle and unknown beats are checked by reading back the state they could have touched.

// File: rtl/rvdp_pkg.sv
package rvdp_pkg;
  localparam int XLEN = 32;

  localparam logic [6:0] OPC_REG   = 7'h33;
  localparam logic [6:0] OPC_IMM   = 7'h13;
  localparam logic [6:0] OPC_LOAD  = 7'h03;
  localparam logic [6:0] OPC_STORE = 7'h23;
  localparam logic [2:0] F3_WORD   = 3'b010;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'b0000,
    ALU_SLL  = 4'b0001,
    ALU_SLT  = 4'b0010,
    ALU_SLTU = 4'b0011,
    ALU_XOR  = 4'b0100,
    ALU_SRL  = 4'b0101,
    ALU_OR   = 4'b0110,
    ALU_AND  = 4'b0111,
    ALU_SUB  = 4'b1000,
    ALU_SRA  = 4'b1101
  } alu_op_e;

  typedef struct packed {
    alu_op_e          op;
    logic             use_imm;
    logic             load;
    logic             store;
    logic             reg_we;
    logic [XLEN-1:0]  imm;
    logic [4:0]       rs1;
    logic [4:0]       rs2;
    logic [4:0]       rd;
  } ctrl_t;
endpackage

// File: rtl/rvdp_decode.sv
module rvdp_decode
  import rvdp_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);
  // Map funct3 plus the alternate bit to an ALU operation; the alternate
  // bit only matters for add/sub and the two right shifts.
  function automatic alu_op_e pick_op(input logic alt, input logic [2:0] f3);
    if (alt && f3 == 3'b000)      return ALU_SUB;
    else if (alt && f3 == 3'b101) return ALU_SRA;
    else                          return alu_op_e'({1'b0, f3});
  endfunction

  logic [6:0] opc;
  logic [2:0] f3;
  logic       alt;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign alt = instr[30];

  always_comb begin
    ctrl         = '0;
    ctrl.op      = ALU_ADD;
    ctrl.rs1     = instr[19:15];
    ctrl.rs2     = instr[24:20];
    ctrl.rd      = instr[11:7];
    ctrl.imm     = {{20{instr[31]}}, instr[31:20]};
    case (opc)
      OPC_REG: begin
        ctrl.reg_we = 1'b1;
        ctrl.op     = pick_op(alt, f3);
      end
      OPC_IMM: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.op      = pick_op(alt && (f3 == 3'b101), f3);
      end
      OPC_LOAD: begin
        if (f3 == F3_WORD) begin
          ctrl.reg_we  = 1'b1;
          ctrl.load    = 1'b1;
          ctrl.use_imm = 1'b1;
        end
      end
      OPC_STORE: begin
        if (f3 == F3_WORD) begin
          ctrl.store   = 1'b1;
          ctrl.use_imm = 1'b1;
          ctrl.imm     = {{20{instr[31]}}, instr[31:25], instr[11:7]};
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rvdp_alu.sv
module rvdp_alu
  import rvdp_pkg::*;
#(
  parameter int W = XLEN,
  localparam int SH_W = $clog2(W)
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [SH_W-1:0] sh;
  assign sh = b[SH_W-1:0];

  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_SLL:  y = a << sh;
      ALU_SLT:  y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: y = {{(W-1){1'b0}}, a < b};
      ALU_XOR:  y = a ^ b;
      ALU_SRL:  y = a >> sh;
      ALU_SRA:  y = $unsigned($signed(a) >>> sh);
      ALU_OR:   y = a | b;
      ALU_AND:  y = a & b;
      default:  y = a + b;
    endcase
  end
endmodule

// File: rtl/rvdp_regfile.sv
module rvdp_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  parameter int NRD  = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end
endmodule

// File: rtl/rvdp_dmem.sv
module rvdp_dmem #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/rvdp_core.sv
module rvdp_core
  import rvdp_pkg::*;
#(
  parameter int  MEM_WORDS = 64,
  localparam int NREG      = 32,
  localparam int RA_W      = $clog2(NREG),
  localparam int ADDR_W    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [31:0]       instr,
  input  logic [RA_W-1:0]   dbg_reg_addr,
  output logic [XLEN-1:0]   dbg_reg_data,
  input  logic [ADDR_W-1:0] dbg_mem_addr,
  output logic [XLEN-1:0]   dbg_mem_data
);
  ctrl_t ctrl;
  logic  fire;

  logic [2:0][RA_W-1:0]   rf_raddr;
  logic [2:0][XLEN-1:0]   rf_rdata;
  logic                   rf_we;
  logic [RA_W-1:0]        rf_waddr;
  logic [XLEN-1:0]        wb_data;
  logic [XLEN-1:0]        rs1_val;
  logic [XLEN-1:0]        rs2_val;

  logic [XLEN-1:0]        alu_b;
  logic [XLEN-1:0]        alu_y;

  logic [1:0][ADDR_W-1:0] mem_raddr;
  logic [1:0][XLEN-1:0]   mem_rdata;
  logic                   mem_we;
  logic [ADDR_W-1:0]      mem_addr;
  logic [XLEN-1:0]        mem_wdata;

  assign instr_ready = rst_n;
  assign fire        = instr_valid && instr_ready;

  rvdp_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl)
  );

  assign rf_raddr = {dbg_reg_addr, ctrl.rs2, ctrl.rs1};
  assign rs1_val  = rf_rdata[0];
  assign rs2_val  = rf_rdata[1];
  assign dbg_reg_data = rf_rdata[2];

  rvdp_regfile #(.NREG(NREG), .W(XLEN), .NRD(3)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (wb_data),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  assign alu_b = ctrl.use_imm ? ctrl.imm : rs2_val;

  rvdp_alu #(.W(XLEN)) u_alu (
    .op (ctrl.op),
    .a  (rs1_val),
    .b  (alu_b),
    .y  (alu_y)
  );

  assign mem_addr     = alu_y[ADDR_W+1:2];
  assign mem_we       = fire && ctrl.store;
  assign mem_wdata    = rs2_val;
  assign mem_raddr    = {dbg_mem_addr, mem_addr};
  assign dbg_mem_data = mem_rdata[1];

  rvdp_dmem #(.WORDS(MEM_WORDS), .W(XLEN), .NRD(2)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  assign wb_data  = ctrl.load ? mem_rdata[0] : alu_y;
  assign rf_we    = fire && ctrl.reg_we;
  assign rf_waddr = ctrl.rd;
endmodule

// File: rtl/rvdp_core_chk.sv
module rvdp_core_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [6:0]        instr_opc,
  input logic [2:0]        instr_f3,
  input logic [4:0]        dbg_reg_addr,
  input logic [31:0]       dbg_reg_data,
  input logic [ADDR_W-1:0] dbg_mem_addr,
  input logic [31:0]       dbg_mem_data,
  input logic              rf_we,
  input logic [4:0]        rf_waddr,
  input logic [31:0]       wb_data,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata
);
  logic known;
  assign known = (instr_opc == 7'h33) || (instr_opc == 7'h13) ||
                 ((instr_opc == 7'h03 || instr_opc == 7'h23) && instr_f3 == 3'b010);

  always_comb begin
    if (!rst_n) begin
      assert_reset_ready_R1: assert (!instr_ready);
    end
  end

  assert_x0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_reg_addr == 5'd0 |-> dbg_reg_data == 32'd0);

  assert_rf_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_waddr != 5'd0 && rf_waddr == dbg_reg_addr)
    |=> (!$stable(dbg_reg_addr) || dbg_reg_data == $past(wb_data)));

  assert_mem_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == dbg_mem_addr)
    |=> (!$stable(dbg_mem_addr) || dbg_mem_data == $past(mem_wdata)));

  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, mem_we}));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!$stable(dbg_reg_addr) || $stable(dbg_reg_data)));

  assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !known) |-> (!rf_we && !mem_we));
endmodule

bind rvdp_core rvdp_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .instr_valid  (instr_valid),
  .instr_ready  (instr_ready),
  .instr_opc    (instr[6:0]),
  .instr_f3     (instr[14:12]),
  .dbg_reg_addr (dbg_reg_addr),
  .dbg_reg_data (dbg_reg_data),
  .dbg_mem_addr (dbg_mem_addr),
  .dbg_mem_data (dbg_mem_data),
  .rf_we        (rf_we),
  .rf_waddr     (rf_waddr),
  .wb_data      (wb_data),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata)
);

// File: tb/rvdp_core_tb.sv
`timescale 1ns/1ps
module rvdp_core_tb;
  localparam int MEM_WORDS = 64;
  localparam int AW = $clog2(MEM_WORDS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_valid = 1'b0;
  logic          instr_ready;
  logic [31:0]   instr = 32'd0;
  logic [4:0]    dbg_reg_addr = 5'd0;
  logic [31:0]   dbg_reg_data;
  logic [AW-1:0] dbg_mem_addr = '0;
  logic [31:0]   dbg_mem_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rvdp_core #(.MEM_WORDS(MEM_WORDS)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .instr_ready  (instr_ready),
    .instr        (instr),
    .dbg_reg_addr (dbg_reg_addr),
    .dbg_reg_data (dbg_reg_data),
    .dbg_mem_addr (dbg_mem_addr),
    .dbg_mem_data (dbg_mem_data)
  );

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'h33};
  endfunction
  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                        logic [4:0] rd);
    return {imm, rs1, f3, rd, 7'h13};
  endfunction
  function automatic logic [31:0] enc_l(logic [11:0] imm, logic [4:0] rs1, logic [4:0] rd);
    return {imm, rs1, 3'b010, rd, 7'h03};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'h23};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic        is_mem;
    logic [7:0]  loc;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{enc_i(12'h005, 0, 3'b000, 1),          1'b0, 8'd1,  32'h0000_0005, 8'd4},  // R4 addi
    '{enc_i(12'hFFD, 0, 3'b000, 2),          1'b0, 8'd2,  32'hFFFF_FFFD, 8'd4},  // R4 negative imm
    '{enc_r(7'h00, 2, 1, 3'b000, 3),         1'b0, 8'd3,  32'h0000_0002, 8'd3},  // R3 add
    '{enc_r(7'h20, 2, 1, 3'b000, 4),         1'b0, 8'd4,  32'h0000_0008, 8'd3},  // R3 sub
    '{enc_s(12'h008, 4, 0),                  1'b1, 8'd2,  32'h0000_0008, 8'd6},  // R6 sw
    '{enc_l(12'h008, 0, 5),                  1'b0, 8'd5,  32'h0000_0008, 8'd5},  // R5 lw
    '{enc_r(7'h00, 1, 1, 3'b001, 6),         1'b0, 8'd6,  32'h0000_00A0, 8'd3},  // R3 sll
    '{enc_r(7'h00, 1, 2, 3'b010, 7),         1'b0, 8'd7,  32'h0000_0001, 8'd3},  // R3 slt
    '{enc_r(7'h00, 1, 2, 3'b011, 8),         1'b0, 8'd8,  32'h0000_0000, 8'd3},  // R3 sltu
    '{enc_r(7'h20, 1, 2, 3'b101, 9),         1'b0, 8'd9,  32'hFFFF_FFFF, 8'd3},  // R3 sra
    '{enc_r(7'h00, 1, 2, 3'b101, 10),        1'b0, 8'd10, 32'h07FF_FFFF, 8'd3},  // R3 srl
    '{enc_i(12'hFFF, 1, 3'b100, 11),         1'b0, 8'd11, 32'hFFFF_FFFA, 8'd4},  // R4 xori
    '{enc_i(12'h030, 1, 3'b110, 12),         1'b0, 8'd12, 32'h0000_0035, 8'd4},  // R4 ori
    '{enc_i(12'h00F, 2, 3'b111, 13),         1'b0, 8'd13, 32'h0000_000D, 8'd4},  // R4 andi
    '{enc_i(12'h401, 2, 3'b101, 14),         1'b0, 8'd14, 32'hFFFF_FFFE, 8'd4},  // R4 srai
    '{enc_i(12'h01C, 2, 3'b101, 15),         1'b0, 8'd15, 32'h0000_000F, 8'd4},  // R4 srli
    '{enc_i(12'h006, 1, 3'b011, 16),         1'b0, 8'd16, 32'h0000_0001, 8'd4},  // R4 sltiu
    '{enc_i(12'hFFC, 2, 3'b010, 17),         1'b0, 8'd17, 32'h0000_0000, 8'd4},  // R4 slti
    '{enc_s(12'hFFC, 2, 4),                  1'b1, 8'd1,  32'hFFFF_FFFD, 8'd6},  // R6 negative offset
    '{enc_l(12'h004, 0, 18),                 1'b0, 8'd18, 32'hFFFF_FFFD, 8'd5},  // R5 lw
    '{enc_i(12'h007, 1, 3'b000, 0),          1'b0, 8'd0,  32'h0000_0000, 8'd2},  // R2 write x0
    '{enc_r(7'h00, 4, 1, 3'b100, 19),        1'b0, 8'd19, 32'h0000_000D, 8'd3},  // R3 xor
    '{enc_r(7'h00, 4, 1, 3'b110, 20),        1'b0, 8'd20, 32'h0000_000D, 8'd3},  // R3 or
    '{enc_r(7'h00, 1, 1, 3'b111, 21),        1'b0, 8'd21, 32'h0000_0005, 8'd3},  // R3 and
    '{enc_i(12'h021, 0, 3'b000, 23),         1'b0, 8'd23, 32'h0000_0021, 8'd4},  // R4 addi 33
    '{enc_r(7'h00, 23, 1, 3'b001, 22),       1'b0, 8'd22, 32'h0000_000A, 8'd3},  // R3 shift low 5 bits
    '{enc_r(7'h20, 1, 1, 3'b111, 24),        1'b0, 8'd24, 32'h0000_0005, 8'd3},  // R3 bit30 ignored on and
    '{enc_s(12'h102, 1, 0),                  1'b1, 8'd0,  32'h0000_0005, 8'd10}, // R10 wrap
    '{enc_l(12'h003, 0, 25),                 1'b0, 8'd25, 32'h0000_0005, 8'd10}  // R10 low bits ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
    dbg_reg_addr = a;
    #1;
    v = dbg_reg_data;
  endtask

  task automatic rd_mem(input logic [AW-1:0] a, output logic [31:0] v);
    dbg_mem_addr = a;
    #1;
    v = dbg_mem_data;
  endtask

  task automatic exec(input logic [31:0] ins, input logic vld);
    @(negedge clk);
    instr = ins;
    instr_valid = vld;
    @(negedge clk);
    instr_valid = 1'b0;
    #1;
  endtask

  initial begin
    logic [31:0] v;
    // Reset state, R1
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", {31'd0, instr_ready}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 ready after reset", {31'd0, instr_ready}, 32'd1);
    rd_reg(5'd7, v);  check("R1 reg zero", v, 32'd0);
    rd_mem(6'd5, v);  check("R1 mem zero", v, 32'd0);

    // Vector table: one instruction, one result, due after the next edge
    for (int i = 0; i < NV; i++) begin
      exec(VECS[i].ins, 1'b1);
      if (VECS[i].is_mem) rd_mem(VECS[i].loc[AW-1:0], v);
      else                rd_reg(VECS[i].loc[4:0], v);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
    end

    // R6: store leaves the register named by bits 11:7 alone (x12 = 0x35)
    exec(enc_s(12'h00C, 1, 0), 1'b1);
    rd_reg(5'd12, v); check("R6 store no reg write", v, 32'h35);
    rd_mem(6'd3, v);  check("R6 store data", v, 32'h5);

    // R8: idle beat with a live-looking instruction
    exec(enc_i(12'h063, 0, 3'b000, 1), 1'b0);
    rd_reg(5'd1, v);  check("R8 idle no write", v, 32'h5);
    exec(enc_s(12'h008, 1, 0), 1'b0);
    rd_mem(6'd2, v);  check("R8 idle no store", v, 32'h8);

    // R9: unknown opcode, byte load, byte store
    exec({12'h063, 5'd0, 3'b000, 5'd1, 7'h7F}, 1'b1);
    rd_reg(5'd1, v);  check("R9 unknown opcode", v, 32'h5);
    exec({12'h008, 5'd0, 3'b000, 5'd1, 7'h03}, 1'b1);
    rd_reg(5'd1, v);  check("R9 byte load ignored", v, 32'h5);
    exec({7'h00, 5'd1, 5'd0, 3'b000, 5'd8, 7'h23}, 1'b1);
    rd_mem(6'd2, v);  check("R9 byte store ignored", v, 32'h8);

    // R7: back-to-back beats, second reads the first's result
    @(negedge clk);
    instr = enc_i(12'h001, 0, 3'b000, 26);
    instr_valid = 1'b1;
    @(negedge clk);
    instr = enc_i(12'h001, 26, 3'b000, 26);
    @(negedge clk);
    instr_valid = 1'b0;
    #1;
    rd_reg(5'd26, v); check("R7 back-to-back", v, 32'd2);

    // R2: read x0 directly after an add targeting it
    exec(enc_r(7'h00, 1, 1, 3'b000, 0), 1'b1);
    rd_reg(5'd0, v);  check("R2 x0 reads zero", v, 32'd0);

    // R1: reset clears state again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    rd_reg(5'd5, v);  check("R1 reg cleared", v, 32'd0);
    rd_mem(6'd2, v);  check("R1 mem cleared", v, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule